// File: doc/BRIEF.md
# Floating-point compare condition unit

This block decides one comparison between two IEEE-754 operands and keeps the result as a one-bit condition flag, the way a branch on that condition would later read it. Each compare gives the raw bit patterns of both operands, a precision select (single or double) and a 4-bit condition field. The field says which of the three relations (less, equal, unordered) make the flag true, and whether a NaN operand must raise a trap.

All sixteen compare variants of each precision go through the same evaluation path and differ only in the condition field. The operands are classified (NaN, zero, sign, magnitude) and then ordered. The predicates are masked by the field and ORed into the flag. This happens on the clock edge where the strobe is high. A signalling compare that meets a NaN raises the invalid-operation flag for one cycle and leaves the condition flag as it was.

Top module: `fp_cond_unit`

## Requirements
- R1: After reset, `cond_flag` and `invalid_flag` are both 0.
- R2: An operand is a NaN only when its exponent field is all ones and its fraction is nonzero, for the selected precision. An infinity (zero fraction) is ordered as a number, and any nonzero fraction bit, even the lowest, makes a NaN.
- R3: If either operand is a NaN, less and equal are 0 and unordered is 1. Otherwise unordered is 0.
- R4: The condition field is encoded as bit 3 signalling, bit 2 less, bit 1 equal, bit 0 unordered. A non-trapping compare sets `cond_flag` to (bit2 AND less) OR (bit1 AND equal) OR (bit0 AND unordered). A field of 0 always gives 0.
- R5: When bit 3 is set and either operand is a NaN, `invalid_flag` is 1 for the one cycle after the strobe, and `cond_flag` keeps its previous value.
- R6: When bit 3 is set and neither operand is a NaN, the compare updates `cond_flag` normally and `invalid_flag` stays 0.
- R7: Without a strobe, `cond_flag` holds its value and `invalid_flag` is 0.
- R8: +0 and -0 compare equal and neither is less than the other.
- R9: Non-NaN operands are ordered first by sign (negative below positive). With equal signs they are ordered by magnitude, and the magnitude order is reversed when both operands are negative.
- R10: With `dbl_sel`=0 only bits 31:0 of each operand take part (1/8/23 layout), and bits 63:32 are ignored. With `dbl_sel`=1 all 64 bits are used (1/11/52 layout).
- R11: The flags are registered. A strobe at a rising edge shows on the outputs after that edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Compare strobe |
| dbl_sel | input | 1 | 1 selects double precision, 0 selects single |
| cond_field | input | 4 | {signalling, less, equal, unordered} |
| op_a | input | 64 | First operand, raw bits |
| op_b | input | 64 | Second operand, raw bits |
| cond_flag | output | 1 | Floating-point condition flag |
| invalid_flag | output | 1 | Invalid-operation trap pulse |

## Verification
On every cycle the assertions check several things. Idle cycles leave the flag alone. A signalling NaN compare pulses the trap and freezes the flag, and a quiet compare never traps. An all-zero field clears the flag. The ordering stage never reports less and equal together, and two zeros always order as equal. The bench scenarios cover what needs known values: the numeric ordering of chosen pairs, infinities versus NaNs in both precisions, the lowest fraction bit, junk in the upper half of a single-precision operand, and the cycle on which the flag changes.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
   // Condition field as seen by the flag stage; bit order is part of the encoding
   typedef struct packed {
      logic sig;   // bit 3: trap on NaN
      logic lt;    // bit 2: accept less
      logic eq;    // bit 1: accept equal
      logic un;    // bit 0: accept unordered
   } cond_t;

   localparam int NUM_FMT = 2;   // index 0 single, index 1 double
endpackage

// File: rtl/fpc_lane.sv
// Splits one operand of a given format into class bits and a magnitude.
module fpc_lane #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   parameter int MAG_W  = 63
) (
   input  logic [EXP_W+FRAC_W:0] raw,
   output logic                  is_nan,
   output logic                  is_zero,
   output logic                  sign,
   output logic [MAG_W-1:0]      mag
);
   localparam int W = 1 + EXP_W + FRAC_W;

   if (W - 1 > MAG_W) begin : g_bad_width
      $error("fpc_lane: format wider than magnitude bus");
   end
   if (EXP_W < 2 || FRAC_W < 1) begin : g_bad_fmt
      $error("fpc_lane: degenerate format");
   end

   logic [EXP_W-1:0]  expo;
   logic [FRAC_W-1:0] frac;

   assign expo    = raw[W-2 -: EXP_W];
   assign frac    = raw[FRAC_W-1:0];
   assign sign    = raw[W-1];
   assign is_nan  = (&expo) & (|frac);
   assign is_zero = ~|raw[W-2:0];

   always_comb begin
      mag          = '0;
      mag[W-2:0]   = raw[W-2:0];
   end
endmodule

// File: rtl/fpc_order.sv
// Sign-magnitude ordering of two non-NaN operands.
module fpc_order #(
   parameter int MAG_W = 63
) (
   input  logic             sign_a,
   input  logic             sign_b,
   input  logic             zero_a,
   input  logic             zero_b,
   input  logic [MAG_W-1:0] mag_a,
   input  logic [MAG_W-1:0] mag_b,
   output logic             lt,
   output logic             eq
);
   logic mag_lt, mag_eq;

   assign mag_lt = mag_a < mag_b;
   assign mag_eq = mag_a == mag_b;

   always_comb begin
      if (zero_a && zero_b) begin
         lt = 1'b0;
         eq = 1'b1;
      end else if (sign_a != sign_b) begin
         lt = sign_a;
         eq = 1'b0;
      end else if (sign_a) begin
         lt = ~mag_lt & ~mag_eq;
         eq = mag_eq;
      end else begin
         lt = mag_lt;
         eq = mag_eq;
      end
   end
endmodule

// File: rtl/fpc_flag_reg.sv
// Masks the predicates and holds the condition and trap flags.
module fpc_flag_reg
   import fpc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strobe,
   input  logic [3:0] cond,
   input  logic       lt,
   input  logic       eq,
   input  logic       un,
   output logic       flag,
   output logic       invalid
);
   cond_t c;
   logic  trap;
   logic  masked;

   assign c      = cond_t'(cond);
   assign trap   = strobe & c.sig & un;
   assign masked = (c.lt & lt) | (c.eq & eq) | (c.un & un);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag    <= 1'b0;
         invalid <= 1'b0;
      end else begin
         invalid <= trap;
         if (strobe && !trap)
            flag <= masked;
      end
   end

   assert_trap_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && cond[3] && un) |=> (invalid && flag == $past(flag)));

   assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> ($stable(flag) && !invalid));

   assert_quiet_no_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !cond[3]) |=> !invalid);

   assert_empty_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && cond == 4'b0000) |=> !flag);
endmodule

// File: rtl/fp_cond_unit.sv
module fp_cond_unit #(
   parameter int SP_EXP_W  = 8,
   parameter int SP_FRAC_W = 23,
   parameter int DP_EXP_W  = 11,
   parameter int DP_FRAC_W = 52
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             cmp_valid,
   input  logic                             dbl_sel,
   input  logic [3:0]                       cond_field,
   input  logic [DP_EXP_W+DP_FRAC_W:0]      op_a,
   input  logic [DP_EXP_W+DP_FRAC_W:0]      op_b,
   output logic                             cond_flag,
   output logic                             invalid_flag
);
   import fpc_pkg::*;

   localparam int SP_W  = 1 + SP_EXP_W + SP_FRAC_W;
   localparam int DP_W  = 1 + DP_EXP_W + DP_FRAC_W;
   localparam int MAG_W = DP_W - 1;

   if (SP_EXP_W >= DP_EXP_W || SP_FRAC_W >= DP_FRAC_W) begin : g_bad_formats
      $error("fp_cond_unit: single format must be narrower than double");
   end

   logic [NUM_FMT-1:0] nan_a, nan_b, zero_a, zero_b, sgn_a, sgn_b;
   logic [MAG_W-1:0]   mag_a [NUM_FMT];
   logic [MAG_W-1:0]   mag_b [NUM_FMT];

   for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
      localparam int EW = (g == 0) ? SP_EXP_W  : DP_EXP_W;
      localparam int FW = (g == 0) ? SP_FRAC_W : DP_FRAC_W;
      localparam int LW = 1 + EW + FW;

      fpc_lane #(.EXP_W(EW), .FRAC_W(FW), .MAG_W(MAG_W)) u_lane_a (
         .raw     (op_a[LW-1:0]),
         .is_nan  (nan_a[g]),
         .is_zero (zero_a[g]),
         .sign    (sgn_a[g]),
         .mag     (mag_a[g])
      );
      fpc_lane #(.EXP_W(EW), .FRAC_W(FW), .MAG_W(MAG_W)) u_lane_b (
         .raw     (op_b[LW-1:0]),
         .is_nan  (nan_b[g]),
         .is_zero (zero_b[g]),
         .sign    (sgn_b[g]),
         .mag     (mag_b[g])
      );
   end

   logic unord, ord_lt, ord_eq, pred_lt, pred_eq;

   assign unord = nan_a[dbl_sel] | nan_b[dbl_sel];

   fpc_order #(.MAG_W(MAG_W)) u_order (
      .sign_a (sgn_a[dbl_sel]),
      .sign_b (sgn_b[dbl_sel]),
      .zero_a (zero_a[dbl_sel]),
      .zero_b (zero_b[dbl_sel]),
      .mag_a  (mag_a[dbl_sel]),
      .mag_b  (mag_b[dbl_sel]),
      .lt     (ord_lt),
      .eq     (ord_eq)
   );

   assign pred_lt = ord_lt & ~unord;
   assign pred_eq = ord_eq & ~unord;

   fpc_flag_reg u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe  (cmp_valid),
      .cond    (cond_field),
      .lt      (pred_lt),
      .eq      (pred_eq),
      .un      (unord),
      .flag    (cond_flag),
      .invalid (invalid_flag)
   );

   assert_order_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(ord_lt && ord_eq));

   assert_zeros_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_a[dbl_sel] && zero_b[dbl_sel]) |-> (ord_eq && !ord_lt));

   assert_nan_unordered_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && !cond_field[3] && unord && cond_field[2:0] == 3'b110) |=> !cond_flag);
endmodule

// File: tb/sim_fp_cond_unit.sv
`timescale 1ns/1ps
module sim_fp_cond_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmp_valid = 1'b0;
   logic        dbl_sel = 1'b0;
   logic [3:0]  cond_field = 4'h0;
   logic [63:0] op_a = '0;
   logic [63:0] op_b = '0;
   logic        cond_flag, invalid_flag;

   int nchk  = 0;
   int nfail = 0;

   localparam logic [63:0] S_P1   = 64'h3F80_0000;
   localparam logic [63:0] S_P2   = 64'h4000_0000;
   localparam logic [63:0] S_M1   = 64'hBF80_0000;
   localparam logic [63:0] S_M2   = 64'hC000_0000;
   localparam logic [63:0] S_PZ   = 64'h0000_0000;
   localparam logic [63:0] S_MZ   = 64'h8000_0000;
   localparam logic [63:0] S_QNAN = 64'h7FC0_0000;
   localparam logic [63:0] S_LNAN = 64'h7F80_0001;
   localparam logic [63:0] S_INF  = 64'h7F80_0000;
   localparam logic [63:0] D_P1   = 64'h3FF0_0000_0000_0000;
   localparam logic [63:0] D_P2   = 64'h4000_0000_0000_0000;
   localparam logic [63:0] D_M2   = 64'hC000_0000_0000_0000;
   localparam logic [63:0] D_QNAN = 64'h7FF8_0000_0000_0000;
   localparam logic [63:0] D_LNAN = 64'h7FF0_0000_0000_0001;
   localparam logic [63:0] D_INF  = 64'h7FF0_0000_0000_0000;

   fp_cond_unit u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmp_valid    (cmp_valid),
      .dbl_sel      (dbl_sel),
      .cond_field   (cond_field),
      .op_a         (op_a),
      .op_b         (op_b),
      .cond_flag    (cond_flag),
      .invalid_flag (invalid_flag)
   );

   always #5 clk = ~clk;

   task automatic check(input logic act, input logic exp, input string what);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: got %0b expected %0b", what, act, exp);
      end
   endtask

   // one strobed compare; outputs sampled at the following falling edge
   task automatic cmp(input logic d, input logic [3:0] c, input logic [63:0] a,
                      input logic [63:0] b, input logic ef, input logic ei, input string what);
      @(negedge clk);
      dbl_sel = d; cond_field = c; op_a = a; op_b = b; cmp_valid = 1'b1;
      @(negedge clk);
      cmp_valid = 1'b0;
      check(cond_flag, ef, {what, " flag"});
      check(invalid_flag, ei, {what, " invalid"});
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(cond_flag, 1'b0, "R1 reset flag");
      check(invalid_flag, 1'b0, "R1 reset invalid");
      rst_n = 1'b1;
   endtask

   task automatic t_order_single;
      cmp(0, 4'h4, S_P1, S_P2, 1, 0, "R9 R4 1<2");
      cmp(0, 4'h4, S_P2, S_P1, 0, 0, "R9 2<1");
      cmp(0, 4'h4, S_M1, S_M2, 0, 0, "R9 -1<-2");
      cmp(0, 4'h4, S_M2, S_M1, 1, 0, "R9 -2<-1");
      cmp(0, 4'h4, S_M1, S_P1, 1, 0, "R9 -1<1");
      cmp(0, 4'h2, S_P2, S_P2, 1, 0, "R4 2==2");
      cmp(0, 4'h6, S_P2, S_P1, 0, 0, "R4 2<=1");
   endtask

   task automatic t_zero;
      cmp(0, 4'h2, S_PZ, S_MZ, 1, 0, "R8 +0==-0");
      cmp(0, 4'h4, S_MZ, S_PZ, 0, 0, "R8 -0<+0");
      cmp(0, 4'h4, S_MZ, S_P1, 1, 0, "R8 -0<1");
   endtask

   task automatic t_nan_single;
      cmp(0, 4'h6, S_QNAN, S_P1, 0, 0, "R3 NaN<=1");
      cmp(0, 4'h1, S_P1, S_QNAN, 1, 0, "R3 unordered");
      cmp(0, 4'h2, S_QNAN, S_QNAN, 0, 0, "R3 NaN==NaN");
      cmp(0, 4'h1, S_LNAN, S_P1, 1, 0, "R2 low fraction bit NaN");
      cmp(0, 4'h1, S_INF, S_P1, 0, 0, "R2 inf not NaN");
      cmp(0, 4'h4, S_P1, S_INF, 1, 0, "R2 1<inf");
   endtask

   task automatic t_hold;
      cmp(0, 4'h4, S_P1, S_P2, 1, 0, "R7 setup");
      @(negedge clk); op_a = S_P2; op_b = S_P1; cond_field = 4'h4;
      repeat (3) @(negedge clk);
      check(cond_flag, 1'b1, "R7 flag held while idle");
      check(invalid_flag, 1'b0, "R7 no trap while idle");
   endtask

   task automatic t_signal;
      cmp(0, 4'h4, S_P2, S_P1, 0, 0, "R5 setup clear");
      cmp(0, 4'h9, S_QNAN, S_P1, 0, 1, "R5 trap keeps 0");
      @(negedge clk);
      check(invalid_flag, 1'b0, "R5 trap is one cycle");
      cmp(0, 4'h4, S_P1, S_P2, 1, 0, "R5 setup set");
      cmp(1, 4'hA, D_P1, D_QNAN, 1, 1, "R5 trap keeps 1");
      cmp(0, 4'hC, S_P1, S_P2, 1, 0, "R6 signalling ordered");
      cmp(0, 4'hA, S_P1, S_P2, 0, 0, "R6 signalling not equal");
   endtask

   task automatic t_double;
      cmp(1, 4'h4, D_P1, D_P2, 1, 0, "R10 dbl 1<2");
      cmp(1, 4'h4, D_M2, D_P1, 1, 0, "R10 dbl -2<1");
      cmp(1, 4'h4, D_P2, D_M2, 0, 0, "R10 dbl 2<-2");
      cmp(1, 4'h1, D_QNAN, D_P1, 1, 0, "R2 dbl NaN");
      cmp(1, 4'h1, D_LNAN, D_P1, 1, 0, "R2 dbl low fraction NaN");
      cmp(1, 4'h1, D_INF, D_P1, 0, 0, "R2 dbl inf not NaN");
   endtask

   task automatic t_width_sel;
      cmp(0, 4'h4, 64'hDEAD_BEEF_3F80_0000, 64'h1234_5678_4000_0000, 1, 0, "R10 upper ignored lt");
      cmp(0, 4'h1, {32'h7FF8_0000, 32'h3F80_0000}, S_P1, 0, 0, "R10 upper NaN ignored");
      cmp(0, 4'h2, 64'hFFFF_FFFF_4000_0000, S_P2, 1, 0, "R10 upper ignored eq");
      cmp(1, 4'h7, S_QNAN, S_PZ, 0, 0, "R10 low word not a double NaN");
   endtask

   task automatic t_mask_zero;
      cmp(0, 4'h1, S_QNAN, S_P1, 1, 0, "R4 setup");
      cmp(0, 4'h0, S_QNAN, S_P1, 0, 0, "R4 empty mask NaN");
      cmp(0, 4'h0, S_P1, S_P1, 0, 0, "R4 empty mask equal");
   endtask

   task automatic t_timing;
      cmp(0, 4'h4, S_P2, S_P1, 0, 0, "R11 setup");
      @(negedge clk);
      dbl_sel = 0; cond_field = 4'h4; op_a = S_P1; op_b = S_P2; cmp_valid = 1'b1;
      #2;
      check(cond_flag, 1'b0, "R11 not before edge");
      @(posedge clk); #1;
      cmp_valid = 1'b0;
      check(cond_flag, 1'b1, "R11 after edge");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      t_reset();
      t_order_single();
      t_zero();
      t_nan_single();
      t_hold();
      t_signal();
      t_double();
      t_width_sel();
      t_mask_zero();
      t_timing();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule